// File: doc/BRIEF.md
# Variable-Width Rijndael Round Engine

This block is the encryption datapath of a Rijndael cipher. It can work on blocks that are 128, 192 or 256 bits wide. The state is held as a byte matrix with four rows and up to eight columns. A narrow block uses only the low-numbered columns, and the columns it does not use are held at zero. Each clock cycle the engine completes one whole round. All 32 byte positions go through their own substitution, then the row rotation, the column mixing and the key addition, all in that same cycle.

The host places the plaintext on `block_i` and round key 0 on `rkey_i`, selects the block and key lengths, and pulses `start_i`. On each cycle after that, the host presents the round key whose index `round_o` shows. The round count is 10, 12 or 14, chosen from the larger of the two lengths. When the last round completes, `done_o` pulses for one cycle and `data_o` holds the ciphertext until the next start. The key schedule lives outside this block. The block expects byte `k` of any 256-bit word at bits `[8k+7:8k]`, with `k = 4*column + row`.

Top module: `rijndael_round_engine`

## Requirements
- R1: While reset is asserted, and after it is released, `busy_o` and `done_o` are low, `round_o` is 0 and `data_o` is all zero.
- R2: A `start_i` seen while idle loads the state with (`block_i` XOR `rkey_i`). In the next cycle `busy_o` is high and `round_o` is 1.
- R3: The length codes are 0 = 128 bits, 1 = 192 bits and 2 = 256 bits. The round count is 10, 12 or 14 for the larger of the block code and the key code. `round_o` counts 1, 2, ... up to that count, one step per cycle. `done_o` rises exactly that many clock edges after the start edge.
- R4: `done_o` is high for exactly one cycle. `busy_o` falls on the same edge that `done_o` rises.
- R5: A `start_i` received while `busy_o` is high is ignored. The run in progress and its result are unchanged.
- R6: Rows 1, 2 and 3 rotate left by 1, 2 and 3 byte positions for 4- and 6-column blocks, and by 1, 3 and 4 positions for 8-column blocks. Output column c of a row takes input column (c + offset) mod the column count.
- R7: Every round except the last applies substitution, rotation, column mixing with coefficients {2,3,1,1} in circulant order, and then key addition. The last round leaves out the column mixing.
- R8: The substitution is the GF(2^8) multiplicative inverse modulo 0x11B (zero maps to zero), followed by the affine transform with constant 0x63.
- R9: Byte positions outside the active columns (4, 6 or 8) are zero in `data_o`, whatever `block_i` and `rkey_i` carry there.
- R10: Length code 3 acts as 256 bits. Both lengths are captured at start, and changing them during a run has no effect.
- R11: While idle and without `start_i`, `data_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an encryption when idle |
| blk_len_i | input | 2 | Block length code |
| key_len_i | input | 2 | Key length code |
| block_i | input | 256 | Plaintext block, sampled at start |
| rkey_i | input | 256 | Round key for the index shown on round_o (key 0 at start) |
| busy_o | output | 1 | Encryption in progress |
| done_o | output | 1 | One-cycle pulse when the last round finishes |
| round_o | output | 4 | Index of the round key consumed at the next edge, 0 when idle |
| data_o | output | 256 | Current state, ciphertext after done_o |

## Verification
Every output comes straight from a register. The start edge therefore shows its effect, `busy_o` high with `round_o` = 1, in the cycle right after that edge. The result of round i appears in the cycle after the edge at which key i is consumed. For a run of Nr rounds, `done_o`, the fall of `busy_o` and the final ciphertext all appear together, Nr edges after the start edge. The bench drives inputs and samples outputs on the falling edge. It supplies key i in the cycle where `round_o` reads i, and it compares the ciphertext and `done_o` only in the cycle that follows the Nr-th edge. One cycle later it checks `done_o` again, this time for low.

// File: rtl/rre_pkg.sv
package rre_pkg;
  localparam int ROWS     = 4;
  localparam int MAX_COLS = 8;
  localparam int NBYTES   = ROWS * MAX_COLS;
  localparam int STATE_W  = 8 * NBYTES;
  localparam int CNT_W    = 4;

  typedef enum logic [1:0] {
    LEN_128 = 2'd0,
    LEN_192 = 2'd1,
    LEN_256 = 2'd2
  } len_e;

  function automatic len_e len_norm(logic [1:0] code);
    return (code == 2'd3) ? LEN_256 : len_e'(code);
  endfunction

  function automatic int cols_of(len_e l);
    return (l == LEN_128) ? 4 : (l == LEN_192) ? 6 : 8;
  endfunction

  function automatic logic [CNT_W-1:0] rounds_for(len_e b, len_e k);
    logic [1:0] m;
    m = (b > k) ? b : k;
    return CNT_W'(10) + CNT_W'({m, 1'b0});
  endfunction

  function automatic logic [STATE_W-1:0] active_mask(len_e l);
    logic [STATE_W-1:0] m;
    m = '0;
    for (int k = 0; k < NBYTES; k++)
      if (k < ROWS * cols_of(l)) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [7:0] xtime(logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // a^254 = a^-1 ; zero stays zero
  function automatic logic [7:0] gf_inv(logic [7:0] a);
    logic [7:0] sq, acc;
    sq  = gf_mul(a, a);
    acc = sq;
    for (int i = 0; i < 6; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(logic [7:0] b, int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_f(logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/rre_sbox.sv
module rre_sbox
  import rre_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  assign byte_o = sbox_f(byte_i);
endmodule

// File: rtl/rre_mixcol.sv
module rre_mixcol
  import rre_pkg::*;
(
  input  logic [31:0] col_i,
  output logic [31:0] col_o
);
  logic [7:0] a [ROWS];
  logic [7:0] d [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_split
    assign a[r] = col_i[8*r +: 8];
    assign d[r] = xtime(a[r]);
  end

  // coefficient 3 = xtime ^ identity
  assign col_o[7:0]   = d[0] ^ d[1] ^ a[1] ^ a[2] ^ a[3];
  assign col_o[15:8]  = a[0] ^ d[1] ^ d[2] ^ a[2] ^ a[3];
  assign col_o[23:16] = a[0] ^ a[1] ^ d[2] ^ d[3] ^ a[3];
  assign col_o[31:24] = d[0] ^ a[0] ^ a[1] ^ a[2] ^ d[3];
endmodule

// File: rtl/rre_round.sv
module rre_round
  import rre_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  input  logic [STATE_W-1:0] rkey_i,
  input  len_e               len_i,
  input  logic               final_i,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] sub_w, shf_w, mix_w;

  for (genvar k = 0; k < NBYTES; k++) begin : g_sub
    rre_sbox u_sbox (.byte_i(state_i[8*k +: 8]), .byte_o(sub_w[8*k +: 8]));
  end

  for (genvar c = 0; c < MAX_COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int OFF8 = (r == 0) ? 0 : (r == 1) ? 1 : (r == 2) ? 3 : 4;
      localparam int SRC4 = (((c % 4) + r) % 4) * ROWS + r;
      localparam int SRC6 = (((c % 6) + r) % 6) * ROWS + r;
      localparam int SRC8 = ((c + OFF8) % 8) * ROWS + r;
      localparam int DST  = c * ROWS + r;
      assign shf_w[8*DST +: 8] = (len_i == LEN_128) ? sub_w[8*SRC4 +: 8] :
                                 (len_i == LEN_192) ? sub_w[8*SRC6 +: 8] :
                                                      sub_w[8*SRC8 +: 8];
    end
    rre_mixcol u_mix (.col_i(shf_w[32*c +: 32]), .col_o(mix_w[32*c +: 32]));
  end

  assign state_o = ((final_i ? shf_w : mix_w) ^ rkey_i) & active_mask(len_i);
endmodule

// File: rtl/rijndael_round_engine.sv
module rijndael_round_engine
  import rre_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         blk_len_i,
  input  logic [1:0]         key_len_i,
  input  logic [STATE_W-1:0] block_i,
  input  logic [STATE_W-1:0] rkey_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   round_o,
  output logic [STATE_W-1:0] data_o
);
  logic [STATE_W-1:0] state_q, round_w, load_w;
  logic [CNT_W-1:0]   round_q, last_w;
  logic               busy_q, done_q, launch_w, final_w;
  len_e               blk_q, key_q, blk_in_w, key_in_w;

  assign blk_in_w = len_norm(blk_len_i);
  assign key_in_w = len_norm(key_len_i);
  assign last_w   = rounds_for(blk_q, key_q);
  assign launch_w = start_i && !busy_q;
  assign final_w  = busy_q && (round_q == last_w);
  assign load_w   = (block_i ^ rkey_i) & active_mask(blk_in_w);

  rre_round u_round (
    .state_i(state_q),
    .rkey_i (rkey_i),
    .len_i  (blk_q),
    .final_i(final_w),
    .state_o(round_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      round_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      blk_q   <= LEN_128;
      key_q   <= LEN_128;
    end else begin
      done_q <= 1'b0;
      if (launch_w) begin
        state_q <= load_w;
        blk_q   <= blk_in_w;
        key_q   <= key_in_w;
        round_q <= CNT_W'(1);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        state_q <= round_w;
        if (final_w) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          round_q <= '0;
        end else begin
          round_q <= round_q + CNT_W'(1);
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign round_o = round_q;
  assign data_o  = state_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R4
  AST_BUSY_END_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q); // R4
  AST_ROUND_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (round_q >= CNT_W'(1) && round_q <= last_w)); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && round_q != last_w) |=> (busy_q && round_q == $past(round_q) + CNT_W'(1))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(state_q)); // R11
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q & ~active_mask(blk_q)) == '0); // R9
  AST_CFG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(blk_q) && $stable(key_q))); // R10
endmodule

// File: tb/rijndael_round_engine_bench.sv
module rijndael_round_engine_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   blk_sel = 2'd0, key_sel = 2'd0;
  logic [255:0] block = '0, rkey = '0;
  logic         busy, done;
  logic [3:0]   round;
  logic [255:0] data;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;
  logic [7:0]   sb [256];
  logic [255:0] rk [15];

  always #10 clk = ~clk;

  rijndael_round_engine u_rijndael_round_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_len_i(blk_sel), .key_len_i(key_sel),
    .block_i(block), .rkey_i(rkey), .busy_o(busy), .done_o(done), .round_o(round), .data_o(data)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; failures++;
      $display("FAIL R3 watchdog actual=%0d cycles expected<150000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rl(logic [7:0] b, int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] xt(logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  // table by generator walk: p steps by 3, q steps by 1/3
  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [255:0] act_mask(int nb);
    logic [255:0] m = '0;
    for (int k = 0; k < 32; k++) if (k < 4 * nb) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [255:0] ref_cipher(int nb, int nr, logic [255:0] blk);
    logic [7:0] s [32];
    logic [7:0] t [32];
    logic [7:0] a0, a1, a2, a3;
    logic [255:0] res;
    int off;
    for (int k = 0; k < 32; k++) s[k] = (k < 4 * nb) ? blk[8*k +: 8] ^ rk[0][8*k +: 8] : 8'h00;
    for (int rd = 1; rd <= nr; rd++) begin
      for (int k = 0; k < 32; k++) s[k] = sb[s[k]];
      for (int k = 0; k < 32; k++) t[k] = 8'h00;
      for (int c = 0; c < nb; c++)
        for (int r = 0; r < 4; r++) begin
          off = (nb == 8) ? ((r == 0) ? 0 : (r == 1) ? 1 : (r == 2) ? 3 : 4) : r;
          t[c*4 + r] = s[((c + off) % nb) * 4 + r];
        end
      for (int c = 0; c < nb; c++) begin
        a0 = t[c*4]; a1 = t[c*4+1]; a2 = t[c*4+2]; a3 = t[c*4+3];
        if (rd != nr) begin
          t[c*4]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
          t[c*4+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
          t[c*4+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
          t[c*4+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
      end
      for (int k = 0; k < 32; k++) s[k] = (k < 4 * nb) ? t[k] ^ rk[rd][8*k +: 8] : 8'h00;
    end
    for (int k = 0; k < 32; k++) res[8*k +: 8] = s[k];
    return res;
  endfunction

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom();
    return v;
  endfunction

  task automatic run_core(input logic [1:0] bsel, input logic [1:0] ksel, input int nb, input int nr,
                          input logic [255:0] blk, input bit interfere, input logic [255:0] exp,
                          input string tag);
    int bad = 0;
    @(negedge clk);
    start = 1'b1; blk_sel = bsel; key_sel = ksel; block = blk; rkey = rk[0];
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && round === 4'd1, "R2 busy and round after start", {busy, round}, {1'b1, 4'd1});
    for (int i = 1; i <= nr; i++) begin
      rkey = rk[i];
      if (round !== 4'(i)) bad++;
      if (interfere && i == 3) begin
        start = 1'b1; block = ~blk; blk_sel = 2'd0; key_sel = 2'd0;
      end
      if (interfere && i == 5) start = 1'b0;
      @(negedge clk);
      if (i < nr && (done !== 1'b0 || busy !== 1'b1)) bad++;
    end
    chk(bad == 0, "R3 round index sequence", 256'(bad), 256'd0);
    chk(done === 1'b1 && busy === 1'b0, "R3 R4 done after last round", {done, busy}, 2'b10);
    chk(data === exp, tag, data, exp);
    chk((data & ~act_mask(nb)) === '0, "R9 unused columns zero", data & ~act_mask(nb), '0);
    @(negedge clk);
    chk(done === 1'b0, "R4 done width", 256'(done), 256'd0);
  endtask

  initial begin
    logic [255:0] blk, exp, held;
    logic [31:0]  w [44];
    logic [31:0]  tw;
    logic [7:0]   rc;
    build_sbox();
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && round === 4'd0 && data === '0, "R1 reset state",
        {busy, done, round}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && round === 4'd0 && data === '0, "R1 after reset release",
        {busy, done, round}, '0);

    for (int b = 0; b < 3; b++)
      for (int k = 0; k < 3; k++) begin
        for (int i = 0; i < 15; i++) rk[i] = rand256();
        blk = rand256();
        exp = ref_cipher(4 + 2 * b, 10 + 2 * ((b > k) ? b : k), blk);
        // 192-bit block with 128-bit key also gets start and length changes mid-run (R5, R10)
        run_core(2'(b), 2'(k), 4 + 2 * b, 10 + 2 * ((b > k) ? b : k), blk, (b == 1 && k == 0), exp,
                 (b == 1 && k == 0) ? "R5 R10 R6 R7 result under mid-run start" : "R6 R7 ciphertext");
      end

    // code 3 behaves as 256 (R10)
    for (int i = 0; i < 15; i++) rk[i] = rand256();
    blk = rand256();
    exp = ref_cipher(8, 14, blk);
    run_core(2'd3, 2'd1, 8, 14, blk, 1'b0, exp, "R10 code 3 as 256-bit block");

    // idle hold (R11)
    held = data;
    block = rand256(); rkey = rand256();
    repeat (5) @(negedge clk);
    chk(data === held, "R11 idle hold", data, held);
    chk(busy === 1'b0 && round === 4'd0, "R11 idle stays idle", {busy, round}, '0);

    // standard 128-bit test vector with bench-side key expansion (R8)
    for (int i = 0; i < 4; i++) w[i] = 32'h03020100 + 32'h04040404 * i;
    rc = 8'h01;
    for (int i = 4; i < 44; i++) begin
      tw = w[i-1];
      if (i % 4 == 0) begin
        tw = {tw[7:0], tw[31:8]};
        tw = {sb[tw[31:24]], sb[tw[23:16]], sb[tw[15:8]], sb[tw[7:0]]};
        tw[7:0] = tw[7:0] ^ rc;
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ tw;
    end
    for (int r = 0; r < 15; r++) rk[r] = '0;
    for (int r = 0; r <= 10; r++) rk[r] = {128'd0, w[4*r+3], w[4*r+2], w[4*r+1], w[4*r]};
    blk = {128'd0, 128'hffeeddccbbaa99887766554433221100};
    exp = {128'd0, 128'h5ac5b47080b7cdd830047b6ad8e0c469};
    run_core(2'd0, 2'd0, 4, 10, blk, 1'b0, exp, "R8 known 128-bit vector");
    chk(ref_cipher(4, 10, blk) === exp, "R8 bench table consistency", ref_cipher(4, 10, blk), exp);

    summary();
  end
endmodule